// File: doc/BRIEF.md
# Peripheral I/O Window Decoder

This block sits beside the configuration register file of a multi-function I/O controller. For each built-in peripheral it takes the configuration already held in registers and works out where that peripheral answers on the host I/O bus. It produces an aligned base address, a valid flag and, for the parallel port, a cleaned-up interrupt number. The peripherals are a floppy controller, a parallel port, two serial ports, a single-byte auxiliary register and a pair of GPIO registers.

Five of the windows take their base from a high/low byte register pair. The GPIO pair takes its base from a 2-bit code. Each host access presents an address with a strobe. The address is compared against every valid window, and one clock later at most one select line is raised, chosen by a fixed priority. The GPIO register pair is kept inside the block, because its write masking is part of the decode behaviour.

All window, base, valid and interrupt outputs are combinational from the configuration inputs. Only the selects and the GPIO registers are clocked.

Top module: `ldev_window_decoder`

## Requirements
- R1: The raw base of a byte-pair window is (high byte << 8) | low byte. It is masked down to 8-byte alignment for the floppy and both serial ports, and to 4-byte alignment for the parallel port. The auxiliary base is not masked.
- R2: A masked base is legal only inside a fixed range. The range is 0x0100..0x0FF8 for the floppy and serial windows, 0x0100..0x0FFC for the parallel window and 0x0100..0x0FFF for the auxiliary window. Outside its range a window's valid output is 0.
- R3: The floppy, parallel, serial 1 and serial 2 windows are valid only when both their global enable input and their own activate input are 1. The auxiliary window needs only its activate input.
- R4: The GPIO window is 2 bytes and is valid when `gpio_en` is 1. `gpio_code` values 0, 1, 2 and 3 give bases 0x00E0, 0x00E2, 0x00E4 and 0x00EA.
- R5: `lpt_irq_out` equals `lpt_irq_in` when the input is 15 or less, and is 0xFF (no interrupt) when the input is above 15.
- R6: `sel` is registered. In the cycle after a clock edge that sees `io_strobe` high, bit k is 1 when `io_addr` lies inside valid window k. The bit order is 0 floppy, 1 parallel, 2 serial 1, 3 serial 2, 4 auxiliary (1 byte), 5 GPIO. After an edge with `io_strobe` low, `sel` is 0.
- R7: When the address falls in several valid windows, only the lowest-numbered bit of R6 is set, so at most one `sel` bit is ever 1.
- R8: A strobed write (`io_write` = 1) to the even GPIO address changes only bits 1:0 of `gpio_reg0` to `io_wdata[1:0]`. Writes to the odd GPIO address leave `gpio_reg1` unchanged. Writes while the GPIO window is invalid change nothing.
- R9: During synchronous active-low reset, `sel` clears to 0, `gpio_reg0` loads 0xFF and `gpio_reg1` loads 0xFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fdc_glb_en | input | 1 | Floppy global enable |
| fdc_act | input | 1 | Floppy activate |
| fdc_hi | input | 8 | Floppy base high byte |
| fdc_lo | input | 8 | Floppy base low byte |
| lpt_glb_en | input | 1 | Parallel global enable |
| lpt_act | input | 1 | Parallel activate |
| lpt_hi | input | 8 | Parallel base high byte |
| lpt_lo | input | 8 | Parallel base low byte |
| lpt_irq_in | input | 8 | Parallel interrupt number as configured |
| ser1_glb_en | input | 1 | Serial 1 global enable |
| ser1_act | input | 1 | Serial 1 activate |
| ser1_hi | input | 8 | Serial 1 base high byte |
| ser1_lo | input | 8 | Serial 1 base low byte |
| ser2_glb_en | input | 1 | Serial 2 global enable |
| ser2_act | input | 1 | Serial 2 activate |
| ser2_hi | input | 8 | Serial 2 base high byte |
| ser2_lo | input | 8 | Serial 2 base low byte |
| aux_act | input | 1 | Auxiliary activate |
| aux_hi | input | 8 | Auxiliary base high byte |
| aux_lo | input | 8 | Auxiliary base low byte |
| gpio_en | input | 1 | GPIO window enable |
| gpio_code | input | 2 | GPIO base select code |
| io_addr | input | 16 | Host I/O address |
| io_strobe | input | 1 | Host access strobe |
| io_write | input | 1 | Host access is a write |
| io_wdata | input | 8 | Host write data |
| fdc_base | output | 16 | Floppy aligned base |
| fdc_valid | output | 1 | Floppy window valid |
| lpt_base | output | 16 | Parallel aligned base |
| lpt_valid | output | 1 | Parallel window valid |
| lpt_irq_out | output | 8 | Parallel interrupt number, 0xFF if none |
| ser1_base | output | 16 | Serial 1 aligned base |
| ser1_valid | output | 1 | Serial 1 window valid |
| ser2_base | output | 16 | Serial 2 aligned base |
| ser2_valid | output | 1 | Serial 2 window valid |
| aux_base | output | 16 | Auxiliary base |
| aux_valid | output | 1 | Auxiliary window valid |
| gpio_base | output | 16 | GPIO base |
| gpio_valid | output | 1 | GPIO window valid |
| sel | output | 6 | Registered one-hot select |
| gpio_reg0 | output | 8 | GPIO register 0 |
| gpio_reg1 | output | 8 | GPIO register 1 |

## Verification
The assertions assume that the configuration inputs and the host address are stable around each rising edge. A `sel` bit is checked against the valid flag seen one cycle earlier, so the configuration must not change during the cycle an access is strobed. The bench changes configuration and strobes only on falling edges. It holds every configuration constant from the strobe until the select has been sampled, and it pulses the strobe for exactly one edge.

// File: rtl/ldev_pkg.sv
// Package: shared constants and per-window geometry for the I/O window
// decoder. Assumes a 16-bit host I/O address space.
package ldev_pkg;

    localparam int ADDR_W   = 16;
    localparam int NUM_WIN  = 5;                 // byte-pair windows
    localparam int NUM_SEL  = NUM_WIN + 1;       // plus the GPIO window
    localparam logic [ADDR_W-1:0] WIN_FLOOR = 16'h0100;

    // Select index of each function, which is also its priority (low wins).
    typedef enum logic [2:0] {
        FN_FDC  = 3'd0,
        FN_LPT  = 3'd1,
        FN_SER1 = 3'd2,
        FN_SER2 = 3'd3,
        FN_AUX  = 3'd4,
        FN_GPIO = 3'd5
    } fn_e;

    // Number of low address bits that a window spans.
    function automatic int win_align_bits(input int idx);
        case (idx)
            0, 2, 3: return 3;
            1:       return 2;
            default: return 0;
        endcase
    endfunction

    // Highest legal aligned base of a window.
    function automatic logic [ADDR_W-1:0] win_ceiling(input int idx);
        case (idx)
            0, 2, 3: return 16'h0FF8;
            1:       return 16'h0FFC;
            default: return 16'h0FFF;
        endcase
    endfunction

    // GPIO base chosen by the 2-bit code.
    function automatic logic [ADDR_W-1:0] gpio_base_of(input logic [1:0] code);
        case (code)
            2'd0:    return 16'h00E0;
            2'd1:    return 16'h00E2;
            2'd2:    return 16'h00E4;
            default: return 16'h00EA;
        endcase
    endfunction

endpackage

// File: rtl/ldev_io_window.sv
// Module: one byte-pair I/O window. Builds the base from two bytes, aligns
// it to the window size, checks the legal range and both enables, and
// compares the host address. Purely combinational; assumes FLOOR and CEIL
// are already aligned to the window size.
module ldev_io_window #(
    parameter int                ADDR_W     = 16,
    parameter int                ALIGN_BITS = 3,
    parameter logic [ADDR_W-1:0] FLOOR      = 16'h0100,
    parameter logic [ADDR_W-1:0] CEIL       = 16'h0FF8
) (
    input  logic              glb_en,
    input  logic              act_en,
    input  logic [7:0]        hi,
    input  logic [7:0]        lo,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] base,
    output logic              valid,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK =
        ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] raw_base;
    logic              in_range;

    // Assemble and align the base address.
    always_comb begin
        raw_base = ADDR_W'({hi, lo});
        base     = raw_base & ALIGN_MASK;
    end

    // Range and enable qualification.
    always_comb begin
        in_range = (base >= FLOOR) && (base <= CEIL);
        valid    = glb_en && act_en && in_range;
    end

    // Address match inside the aligned window.
    always_comb begin
        hit = valid && ((addr & ALIGN_MASK) == base);
    end

endmodule

// File: rtl/ldev_gpio_window.sv
// Module: the 2-byte GPIO window, whose base comes from a 2-bit code rather
// than a byte pair. Purely combinational.
module ldev_gpio_window
    import ldev_pkg::*;
(
    input  logic              en,
    input  logic [1:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] base,
    output logic              valid,
    output logic              hit
);
    // Base lookup and address match on all but the lowest bit.
    always_comb begin
        base  = gpio_base_of(code);
        valid = en;
        hit   = en && (addr[ADDR_W-1:1] == base[ADDR_W-1:1]);
    end

endmodule

// File: rtl/ldev_gpio_regs.sv
// Module: the GPIO register pair. Register 0 accepts only bits 1:0 on a
// write; register 1 is read-only and holds its reset value. Assumes
// wr_en is already qualified by strobe, write and window hit.
module ldev_gpio_regs #(
    parameter logic [7:0] RST0 = 8'hFF,
    parameter logic [7:0] RST1 = 8'hFD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       addr_odd,
    input  logic [7:0] wdata,
    output logic [7:0] reg0,
    output logic [7:0] reg1
);
    localparam logic [7:0] WR_MASK = 8'h03;

    // Register 0: masked write of the low two bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg0 <= RST0;
        else if (wr_en && !addr_odd)
            reg0 <= (reg0 & ~WR_MASK) | (wdata & WR_MASK);
    end

    // Register 1: loaded at reset, never written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg1 <= RST1;
    end

endmodule

// File: rtl/ldev_sel_arbiter.sv
// Module: fixed-priority select. Keeps the lowest-numbered hit and
// registers it. Outputs zero after an edge without a strobe.
module ldev_sel_arbiter #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [N-1:0] hits,
    output logic [N-1:0] sel_q
);
    logic [N-1:0] grant;

    // Isolate the lowest set bit of the hit vector.
    always_comb begin
        grant = hits & (~hits + N'(1));
    end

    // Register the grant for one strobed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (strobe)
            sel_q <= grant;
        else
            sel_q <= '0;
    end

endmodule

// File: rtl/ldev_window_decoder.sv
// Module: top of the peripheral I/O window decoder. Instantiates the five
// byte-pair windows in a generate loop, plus the GPIO window, the GPIO
// register pair and the select arbiter. Assumes configuration inputs are
// static while an access is strobed.
module ldev_window_decoder
    import ldev_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fdc_glb_en,
    input  logic        fdc_act,
    input  logic [7:0]  fdc_hi,
    input  logic [7:0]  fdc_lo,
    input  logic        lpt_glb_en,
    input  logic        lpt_act,
    input  logic [7:0]  lpt_hi,
    input  logic [7:0]  lpt_lo,
    input  logic [7:0]  lpt_irq_in,
    input  logic        ser1_glb_en,
    input  logic        ser1_act,
    input  logic [7:0]  ser1_hi,
    input  logic [7:0]  ser1_lo,
    input  logic        ser2_glb_en,
    input  logic        ser2_act,
    input  logic [7:0]  ser2_hi,
    input  logic [7:0]  ser2_lo,
    input  logic        aux_act,
    input  logic [7:0]  aux_hi,
    input  logic [7:0]  aux_lo,
    input  logic        gpio_en,
    input  logic [1:0]  gpio_code,
    input  logic [15:0] io_addr,
    input  logic        io_strobe,
    input  logic        io_write,
    input  logic [7:0]  io_wdata,
    output logic [15:0] fdc_base,
    output logic        fdc_valid,
    output logic [15:0] lpt_base,
    output logic        lpt_valid,
    output logic [7:0]  lpt_irq_out,
    output logic [15:0] ser1_base,
    output logic        ser1_valid,
    output logic [15:0] ser2_base,
    output logic        ser2_valid,
    output logic [15:0] aux_base,
    output logic        aux_valid,
    output logic [15:0] gpio_base,
    output logic        gpio_valid,
    output logic [5:0]  sel,
    output logic [7:0]  gpio_reg0,
    output logic [7:0]  gpio_reg1
);
    localparam logic [7:0] IRQ_MAX  = 8'd15;
    localparam logic [7:0] IRQ_NONE = 8'hFF;

    logic [NUM_WIN-1:0]    w_glb, w_act, w_valid, w_hit;
    logic [7:0]            w_hi   [NUM_WIN];
    logic [7:0]            w_lo   [NUM_WIN];
    logic [ADDR_W-1:0]     w_base [NUM_WIN];
    logic                  g_hit;
    logic [NUM_SEL-1:0]    all_hits;

    // Gather per-window configuration into arrays; auxiliary has no global enable.
    always_comb begin
        w_glb = {1'b1, ser2_glb_en, ser1_glb_en, lpt_glb_en, fdc_glb_en};
        w_act = {aux_act, ser2_act, ser1_act, lpt_act, fdc_act};
        w_hi[FN_FDC]  = fdc_hi;   w_lo[FN_FDC]  = fdc_lo;
        w_hi[FN_LPT]  = lpt_hi;   w_lo[FN_LPT]  = lpt_lo;
        w_hi[FN_SER1] = ser1_hi;  w_lo[FN_SER1] = ser1_lo;
        w_hi[FN_SER2] = ser2_hi;  w_lo[FN_SER2] = ser2_lo;
        w_hi[FN_AUX]  = aux_hi;   w_lo[FN_AUX]  = aux_lo;
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        ldev_io_window #(
            .ADDR_W     (ADDR_W),
            .ALIGN_BITS (win_align_bits(i)),
            .FLOOR      (WIN_FLOOR),
            .CEIL       (win_ceiling(i))
        ) u_win (
            .glb_en (w_glb[i]),
            .act_en (w_act[i]),
            .hi     (w_hi[i]),
            .lo     (w_lo[i]),
            .addr   (io_addr),
            .base   (w_base[i]),
            .valid  (w_valid[i]),
            .hit    (w_hit[i])
        );
    end

    ldev_gpio_window u_gpio_win (
        .en    (gpio_en),
        .code  (gpio_code),
        .addr  (io_addr),
        .base  (gpio_base),
        .valid (gpio_valid),
        .hit   (g_hit)
    );

    ldev_gpio_regs #(
        .RST0 (8'hFF),
        .RST1 (8'hFD)
    ) u_gpio_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (io_strobe && io_write && g_hit),
        .addr_odd (io_addr[0]),
        .wdata    (io_wdata),
        .reg0     (gpio_reg0),
        .reg1     (gpio_reg1)
    );

    // Combine hits in priority order: byte-pair windows low, GPIO highest index.
    always_comb begin
        all_hits = {g_hit, w_hit};
    end

    ldev_sel_arbiter #(
        .N (NUM_SEL)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (io_strobe),
        .hits   (all_hits),
        .sel_q  (sel)
    );

    // Fan the window results out to named ports.
    always_comb begin
        fdc_base   = w_base[FN_FDC];   fdc_valid  = w_valid[FN_FDC];
        lpt_base   = w_base[FN_LPT];   lpt_valid  = w_valid[FN_LPT];
        ser1_base  = w_base[FN_SER1];  ser1_valid = w_valid[FN_SER1];
        ser2_base  = w_base[FN_SER2];  ser2_valid = w_valid[FN_SER2];
        aux_base   = w_base[FN_AUX];   aux_valid  = w_valid[FN_AUX];
    end

    // Parallel interrupt number, clamped to "none" when out of range.
    always_comb begin
        lpt_irq_out = (lpt_irq_in > IRQ_MAX) ? IRQ_NONE : lpt_irq_in;
    end

endmodule

// File: rtl/ldev_window_decoder_chk.sv
// Module: assertion checker for the I/O window decoder, bound to the top.
// Assumes configuration is stable across a strobed cycle.
module ldev_window_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_strobe,
    input logic [7:0]  lpt_irq_in,
    input logic [7:0]  lpt_irq_out,
    input logic [15:0] fdc_base,
    input logic        fdc_valid,
    input logic [15:0] lpt_base,
    input logic        lpt_valid,
    input logic        aux_valid,
    input logic        gpio_valid,
    input logic [5:0]  sel,
    input logic [7:0]  gpio_reg0,
    input logic [7:0]  gpio_reg1
);
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_sel_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strobe |=> (sel == 6'd0));

    p_sel_fdc_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fdc_valid |=> !sel[0]);

    p_sel_aux_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_valid |=> !sel[4]);

    p_sel_gpio_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_valid |=> !sel[5]);

    p_fdc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fdc_valid |-> (fdc_base >= 16'h0100 && fdc_base <= 16'h0FF8 && fdc_base[2:0] == 3'd0));

    p_lpt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lpt_valid |-> (lpt_base >= 16'h0100 && lpt_base <= 16'h0FFC && lpt_base[1:0] == 2'd0));

    p_lpt_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lpt_irq_in > 8'd15) |-> (lpt_irq_out == 8'hFF));

    p_gpio_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(gpio_reg0[7:2]));

    p_gpio_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(gpio_reg1));

endmodule

bind ldev_window_decoder ldev_window_decoder_chk u_chk (.*);

// File: tb/ldev_window_decoder_test.sv
module ldev_window_decoder_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fdc_glb_en, fdc_act, lpt_glb_en, lpt_act;
    logic        ser1_glb_en, ser1_act, ser2_glb_en, ser2_act, aux_act;
    logic [7:0]  fdc_hi, fdc_lo, lpt_hi, lpt_lo, lpt_irq_in;
    logic [7:0]  ser1_hi, ser1_lo, ser2_hi, ser2_lo, aux_hi, aux_lo;
    logic        gpio_en;
    logic [1:0]  gpio_code;
    logic [15:0] io_addr;
    logic        io_strobe, io_write;
    logic [7:0]  io_wdata;
    logic [15:0] fdc_base, lpt_base, ser1_base, ser2_base, aux_base, gpio_base;
    logic        fdc_valid, lpt_valid, ser1_valid, ser2_valid, aux_valid, gpio_valid;
    logic [7:0]  lpt_irq_out, gpio_reg0, gpio_reg1;
    logic [5:0]  sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    ldev_window_decoder uut (.*);

    // Floppy vectors: {hi, lo, glb, act, expected base, expected valid}
    localparam int NV = 10;
    localparam logic [34:0] FDC_VEC [NV] = '{
        {8'h03, 8'hF0, 1'b1, 1'b1, 16'h03F0, 1'b1},
        {8'h03, 8'hF5, 1'b1, 1'b1, 16'h03F0, 1'b1},
        {8'h00, 8'hF8, 1'b1, 1'b1, 16'h00F8, 1'b0},
        {8'h01, 8'h00, 1'b1, 1'b1, 16'h0100, 1'b1},
        {8'h0F, 8'hFF, 1'b1, 1'b1, 16'h0FF8, 1'b1},
        {8'h10, 8'h00, 1'b1, 1'b1, 16'h1000, 1'b0},
        {8'h03, 8'hF0, 1'b0, 1'b1, 16'h03F0, 1'b0},
        {8'h03, 8'hF0, 1'b1, 1'b0, 16'h03F0, 1'b0},
        {8'h00, 8'hFF, 1'b1, 1'b1, 16'h00F8, 1'b0},
        {8'h02, 8'hFB, 1'b1, 1'b1, 16'h02F8, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One strobed access; returns sel sampled on the following falling edge.
    task automatic access(input logic [15:0] a, input logic wr, input logic [7:0] d,
                          output logic [5:0] got);
        @(negedge clk);
        io_addr = a; io_write = wr; io_wdata = d; io_strobe = 1'b1;
        @(negedge clk);
        got = sel;
        io_strobe = 1'b0; io_write = 1'b0;
    endtask

    task automatic set_defaults();
        fdc_glb_en = 1; fdc_act = 1; fdc_hi = 8'h03; fdc_lo = 8'hF0;
        lpt_glb_en = 1; lpt_act = 1; lpt_hi = 8'h03; lpt_lo = 8'h78; lpt_irq_in = 8'd7;
        ser1_glb_en = 1; ser1_act = 1; ser1_hi = 8'h03; ser1_lo = 8'hF8;
        ser2_glb_en = 1; ser2_act = 1; ser2_hi = 8'h02; ser2_lo = 8'hF8;
        aux_act = 1; aux_hi = 8'h02; aux_lo = 8'h00;
        gpio_en = 1; gpio_code = 2'd3;
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] s;
        rst_n = 0; io_addr = 0; io_strobe = 0; io_write = 0; io_wdata = 0;
        set_defaults();
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 sel", 32'(sel), 32'h0);
        chk("R9 gpio_reg0", 32'(gpio_reg0), 32'hFF);
        chk("R9 gpio_reg1", 32'(gpio_reg1), 32'hFD);
        rst_n = 1;

        // R1 R2 R3: floppy vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fdc_hi = FDC_VEC[i][34:27]; fdc_lo = FDC_VEC[i][26:19];
            fdc_glb_en = FDC_VEC[i][18]; fdc_act = FDC_VEC[i][17];
            #1;
            chk("R1 fdc_base", 32'(fdc_base), 32'(FDC_VEC[i][16:1]));
            chk("R2/R3 fdc_valid", 32'(fdc_valid), 32'(FDC_VEC[i][0]));
        end
        set_defaults();

        // R1 R2: parallel 4-byte alignment and ceiling
        @(negedge clk); lpt_hi = 8'h0F; lpt_lo = 8'hFF; #1;
        chk("R1 lpt_base", 32'(lpt_base), 32'h0FFC);
        chk("R2 lpt_valid top", 32'(lpt_valid), 32'h1);
        @(negedge clk); lpt_hi = 8'h10; lpt_lo = 8'h02; #1;
        chk("R2 lpt_valid over", 32'(lpt_valid), 32'h0);
        // R1 R2 R3: auxiliary unmasked, no global enable
        @(negedge clk); aux_hi = 8'h0F; aux_lo = 8'hFF; #1;
        chk("R1 aux_base", 32'(aux_base), 32'h0FFF);
        chk("R2 aux_valid top", 32'(aux_valid), 32'h1);
        @(negedge clk); aux_hi = 8'h10; aux_lo = 8'h00; #1;
        chk("R2 aux_valid over", 32'(aux_valid), 32'h0);
        @(negedge clk); aux_hi = 8'h02; aux_lo = 8'h00; aux_act = 0; #1;
        chk("R3 aux_valid inactive", 32'(aux_valid), 32'h0);
        // R3: serial global enables are independent
        @(negedge clk); set_defaults(); ser1_glb_en = 0; #1;
        chk("R3 ser1_valid glb off", 32'(ser1_valid), 32'h0);
        chk("R3 ser2_valid", 32'(ser2_valid), 32'h1);
        chk("R1 ser2_base", 32'(ser2_base), 32'h02F8);
        @(negedge clk); ser1_glb_en = 1; ser2_act = 0; #1;
        chk("R3 ser2_valid act off", 32'(ser2_valid), 32'h0);
        chk("R3 ser1_valid", 32'(ser1_valid), 32'h1);

        // R4: GPIO base codes
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); gpio_en = 1; gpio_code = 2'(c); #1;
            chk("R4 gpio_base", 32'(gpio_base), (c == 3) ? 32'hEA : 32'(16'h00E0 + 16'(2 * c)));
            chk("R4 gpio_valid", 32'(gpio_valid), 32'h1);
        end
        @(negedge clk); gpio_en = 0; #1;
        chk("R4 gpio_valid off", 32'(gpio_valid), 32'h0);

        // R5: parallel interrupt clamp
        @(negedge clk); lpt_irq_in = 8'd15; #1;
        chk("R5 irq 15", 32'(lpt_irq_out), 32'd15);
        @(negedge clk); lpt_irq_in = 8'd16; #1;
        chk("R5 irq 16", 32'(lpt_irq_out), 32'hFF);
        @(negedge clk); lpt_irq_in = 8'd0; #1;
        chk("R5 irq 0", 32'(lpt_irq_out), 32'd0);

        // R6: one select per window
        set_defaults();
        access(16'h03F3, 0, 0, s); chk("R6 sel fdc", 32'(s), 32'h01);
        access(16'h037A, 0, 0, s); chk("R6 sel lpt", 32'(s), 32'h02);
        access(16'h037C, 0, 0, s); chk("R6 sel past lpt", 32'(s), 32'h00);
        access(16'h03FF, 0, 0, s); chk("R6 sel ser1", 32'(s), 32'h04);
        access(16'h02F8, 0, 0, s); chk("R6 sel ser2", 32'(s), 32'h08);
        access(16'h0200, 0, 0, s); chk("R6 sel aux", 32'(s), 32'h10);
        access(16'h0201, 0, 0, s); chk("R6 sel aux 1 byte", 32'(s), 32'h00);
        access(16'h00EB, 0, 0, s); chk("R6 sel gpio", 32'(s), 32'h20);
        access(16'h00EC, 0, 0, s); chk("R6 sel past gpio", 32'(s), 32'h00);
        @(negedge clk); io_addr = 16'h03F3; @(negedge clk);
        chk("R6 sel no strobe", 32'(sel), 32'h00);

        // R7: overlap priority
        ser1_lo = 8'hF0;
        access(16'h03F4, 0, 0, s); chk("R7 fdc over ser1", 32'(s), 32'h01);
        fdc_act = 0;
        access(16'h03F4, 0, 0, s); chk("R7 ser1 after fdc off", 32'(s), 32'h04);
        set_defaults();
        aux_hi = 8'h03; aux_lo = 8'h78;
        access(16'h0378, 0, 0, s); chk("R7 lpt over aux", 32'(s), 32'h02);
        set_defaults();

        // R8: GPIO register writes
        access(16'h00EA, 1, 8'h00, s);
        @(negedge clk); chk("R8 reg0 low bits", 32'(gpio_reg0), 32'hFC);
        access(16'h00EA, 1, 8'hF1, s);
        @(negedge clk); chk("R8 reg0 upper kept", 32'(gpio_reg0), 32'hFD);
        access(16'h00EB, 1, 8'h00, s);
        @(negedge clk); chk("R8 reg1 ignored", 32'(gpio_reg1), 32'hFD);
        chk("R8 reg0 untouched by odd", 32'(gpio_reg0), 32'hFD);
        gpio_en = 0;
        access(16'h00EA, 1, 8'h02, s);
        @(negedge clk); chk("R8 reg0 window off", 32'(gpio_reg0), 32'hFD);
        gpio_en = 1;
        access(16'h00EA, 0, 8'h02, s);
        @(negedge clk); chk("R8 reg0 read no change", 32'(gpio_reg0), 32'hFD);

        // R9: reset again restores registers
        @(negedge clk); rst_n = 0; @(negedge clk);
        chk("R9 reg0 after reset", 32'(gpio_reg0), 32'hFF);
        chk("R9 sel after reset", 32'(sel), 32'h00);
        rst_n = 1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule